// File: doc/BRIEF.md
# Packed Instruction Word Decoder

This block is the fetch and decode front end of a small stack processor. Program memory holds 16-bit words. A word whose top bit is clear carries two 8-bit opcodes. A word whose top bit is set is a complete subroutine call whose target is the remaining 15 bits doubled, so calls always land on even byte addresses. The decoder fetches a word, hands out its contents one per cycle in the order the processor must run them, and fetches again only when nothing is left to issue.

Some opcodes need a 16-bit operand: the word literal, the jumps, the conditional jumps and the counted-loop branch. For these, the decoder spends the slot cycle recognising the opcode. It then fetches the next memory word and issues the opcode together with that word as its operand, in the cycle the word arrives. The execution side reports a taken jump or a return on a redirect input in the same cycle as the opcode issues. The decoder then drops any unissued slot and restarts fetching at the new address. Memory signals readiness with a ready input, and the decoder simply waits while it is low.

The state machine has four states:

| State | Role |
|---|---|
| `ST_FETCH` | Request the word at the PC. |
| `ST_HI` | Issue the upper slot or the call. |
| `ST_LO` | Issue the lower slot. |
| `ST_OPND` | Request the operand word and issue the waiting opcode with it. |

The transitions are:

- From `ST_FETCH` to `ST_HI` when ready is high.
- From `ST_HI` to `ST_FETCH` on a call, to `ST_OPND` for an operand opcode, and to `ST_LO` otherwise.
- From `ST_LO` to `ST_OPND` for an operand opcode, and to `ST_FETCH` otherwise.
- From `ST_OPND`, when ready is high, back to `ST_LO` if the opcode came from the upper slot, and to `ST_FETCH` otherwise.
- From any state to `ST_FETCH` on a redirect.

Top module: `pword_decoder`

## Requirements
- R1: During and right after reset, `fetch_req` is 1, `fetch_addr` equals `RESET_PC` (0 by default), and neither `op_valid` nor `call_valid` is asserted.
- R2: A fetch completes in a cycle with `fetch_req` and `mem_ready` both high, and the data word is `mem_rdata` in that cycle. Each completed fetch, whether of an instruction word or an operand word, advances `fetch_addr` by 2. `fetch_req` is high only while a word is being requested.
- R3: In a word with bit 15 equal to 0, the upper byte (bits 15:8) issues on `op_code` in the cycle after the fetch completes, and the lower byte (bits 7:0) issues in the following cycle. The next fetch is requested in the cycle after that.
- R4: In a word with bit 15 equal to 1, the cycle after the fetch drives `call_valid` high. In that cycle, `call_target` is {bits 14:0, 0} and `call_return` is the fetched word's address plus 2. The next fetch then requests `call_target`.
- R5: An opcode whose upper five bits are 01111 (0x78 to 0x7F) takes an operand. Its slot cycle issues nothing. The next cycle requests the word at the current `fetch_addr`, and in the cycle that word is ready, `op_valid`, `op_has_operand` and the opcode are driven, with `op_operand` equal to `mem_rdata`.
- R6: After an operand opcode taken from the upper slot, the lower slot of the same word issues in the next cycle. After one taken from the lower slot, the next instruction word is requested.
- R7: While `mem_ready` is low during a request, `fetch_req` stays high, `fetch_addr` is unchanged, and `op_valid` is low.
- R8: A cycle with `redir_valid` high makes the next cycle request `redir_target`. Any slot or call of the current word that has not yet issued is discarded, and redirect takes priority over every other PC change.
- R9: `op_valid` and `call_valid` are never high together, and `op_has_operand` is high only together with `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | WORD_W | Word read from program memory |
| mem_ready | input | 1 | Memory has the requested word this cycle |
| redir_valid | input | 1 | Taken jump or return from execution |
| redir_target | input | WORD_W | Byte address to continue from |
| fetch_req | output | 1 | A word is being requested |
| fetch_addr | output | WORD_W | Byte address of the requested word (the PC) |
| op_valid | output | 1 | An opcode issues this cycle |
| op_code | output | WORD_W/2 | The issued opcode |
| op_has_operand | output | 1 | The issued opcode carries an operand |
| op_operand | output | WORD_W | Operand word, zero when none |
| call_valid | output | 1 | A call issues this cycle |
| call_target | output | WORD_W | Even call target address |
| call_return | output | WORD_W | Address following the call word |

## Verification
The hardest case to reach from the ports is an operand opcode in the upper slot, with memory stalling during the operand fetch, followed by a taken jump that must throw away the still-pending lower slot. The bench runs a small looping program that holds such a jump, a call into a routine that ends in a return, and operand opcodes in both slots. It replays that program under three `mem_ready` patterns: always ready, a periodic bubble, and long stalls. Because the patterns shift how instruction cycles line up with memory stalls, each corner is reached in many alignments. The bench acts as the execution side: it raises redirects on the jump and return opcodes of its own reference model.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_HI    = 2'd1,
        ST_LO    = 2'd2,
        ST_OPND  = 2'd3
    } pwd_state_e;

    // Opcodes whose five upper bits read 01111 carry a following operand word.
    localparam logic [4:0] OPND_CLASS = 5'b01111;

    function automatic logic slot_wants_operand(input logic [4:0] top5);
        return top5 == OPND_CLASS;
    endfunction

endpackage

// File: rtl/pwd_slot_split.sv
module pwd_slot_split #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0]              word,
    output logic                           is_call,
    output logic [WORD_W-1:0]              call_tgt,
    output logic [1:0][WORD_W/2-1:0]       slot_op,
    output logic [1:0]                     slot_opnd
);
    localparam int SLOT_W = WORD_W / 2;

    assign is_call  = word[WORD_W-1];
    assign call_tgt = {word[WORD_W-2:0], 1'b0};

    // Slot 1 is the upper half, slot 0 the lower half.
    for (genvar s = 0; s < 2; s++) begin : g_slot
        assign slot_op[s]   = word[s*SLOT_W +: SLOT_W];
        assign slot_opnd[s] = pwd_pkg::slot_wants_operand(slot_op[s][SLOT_W-1 -: 5]);
    end

endmodule

// File: rtl/pwd_pc.sv
module pwd_pc #(
    parameter int               ADDR_W   = 16,
    parameter int               STEP     = 2,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] pc
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_PC;
        end else if (load) begin
            pc <= load_val;
        end else if (step) begin
            pc <= pc + STEP_V;
        end
    end

endmodule

// File: rtl/pwd_fsm.sv
module pwd_fsm #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic              redir_valid,
    input  logic              is_call,
    input  logic [1:0]        slot_opnd,
    output logic [WORD_W-1:0] word_q,
    output logic              fetch_req,
    output logic              op_valid,
    output logic              op_sel_hi,
    output logic              op_has_operand,
    output logic              call_valid
);
    import pwd_pkg::*;

    pwd_state_e state_q, state_d;
    logic       ret_lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            ret_lo_q <= 1'b0;
        end else begin
            if (state_q == ST_FETCH && mem_ready) begin
                word_q <= mem_rdata;
            end
            if (state_q == ST_HI) begin
                ret_lo_q <= 1'b1;
            end else if (state_q == ST_LO) begin
                ret_lo_q <= 1'b0;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: if (mem_ready) state_d = ST_HI;
            ST_HI: begin
                if (is_call)           state_d = ST_FETCH;
                else if (slot_opnd[1]) state_d = ST_OPND;
                else                   state_d = ST_LO;
            end
            ST_LO:   state_d = slot_opnd[0] ? ST_OPND : ST_FETCH;
            ST_OPND: if (mem_ready) state_d = ret_lo_q ? ST_LO : ST_FETCH;
            default: state_d = ST_FETCH;
        endcase
        if (redir_valid) begin
            state_d = ST_FETCH;
        end
    end

    always_comb begin
        fetch_req      = 1'b0;
        op_valid       = 1'b0;
        op_sel_hi      = 1'b0;
        op_has_operand = 1'b0;
        call_valid     = 1'b0;
        unique case (state_q)
            ST_FETCH: fetch_req = 1'b1;
            ST_HI: begin
                op_sel_hi  = 1'b1;
                call_valid = is_call;
                op_valid   = !is_call && !slot_opnd[1];
            end
            ST_LO: op_valid = !slot_opnd[0];
            ST_OPND: begin
                fetch_req      = 1'b1;
                op_sel_hi      = ret_lo_q;
                op_valid       = mem_ready;
                op_has_operand = mem_ready;
            end
            default: fetch_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/pword_decoder.sv
module pword_decoder #(
    parameter int                WORD_W   = 16,
    parameter logic [WORD_W-1:0] RESET_PC = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WORD_W-1:0]     mem_rdata,
    input  logic                  mem_ready,
    input  logic                  redir_valid,
    input  logic [WORD_W-1:0]     redir_target,
    output logic                  fetch_req,
    output logic [WORD_W-1:0]     fetch_addr,
    output logic                  op_valid,
    output logic [WORD_W/2-1:0]   op_code,
    output logic                  op_has_operand,
    output logic [WORD_W-1:0]     op_operand,
    output logic                  call_valid,
    output logic [WORD_W-1:0]     call_target,
    output logic [WORD_W-1:0]     call_return
);
    localparam int WORD_BYTES = WORD_W / 8;

    logic [WORD_W-1:0]          word_q;
    logic                       is_call;
    logic [1:0][WORD_W/2-1:0]   slot_op;
    logic [1:0]                 slot_opnd;
    logic                       op_sel_hi;
    logic [WORD_W-1:0]          pc;

    pwd_slot_split #(.WORD_W(WORD_W)) split_i (
        .word      (word_q),
        .is_call   (is_call),
        .call_tgt  (call_target),
        .slot_op   (slot_op),
        .slot_opnd (slot_opnd)
    );

    pwd_fsm #(.WORD_W(WORD_W)) fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .mem_rdata      (mem_rdata),
        .mem_ready      (mem_ready),
        .redir_valid    (redir_valid),
        .is_call        (is_call),
        .slot_opnd      (slot_opnd),
        .word_q         (word_q),
        .fetch_req      (fetch_req),
        .op_valid       (op_valid),
        .op_sel_hi      (op_sel_hi),
        .op_has_operand (op_has_operand),
        .call_valid     (call_valid)
    );

    pwd_pc #(.ADDR_W(WORD_W), .STEP(WORD_BYTES), .RESET_PC(RESET_PC)) pc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (redir_valid || call_valid),
        .load_val (redir_valid ? redir_target : call_target),
        .step     (fetch_req && mem_ready),
        .pc       (pc)
    );

    assign fetch_addr  = pc;
    assign call_return = pc;
    assign op_code     = op_sel_hi ? slot_op[1] : slot_op[0];
    assign op_operand  = op_has_operand ? mem_rdata : '0;

endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
    parameter int WORD_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [WORD_W-1:0]   mem_rdata,
    input logic                mem_ready,
    input logic                redir_valid,
    input logic [WORD_W-1:0]   redir_target,
    input logic                fetch_req,
    input logic [WORD_W-1:0]   fetch_addr,
    input logic                op_valid,
    input logic [WORD_W/2-1:0] op_code,
    input logic                op_has_operand,
    input logic [WORD_W-1:0]   op_operand,
    input logic                call_valid,
    input logic [WORD_W-1:0]   call_target,
    input logic [WORD_W-1:0]   call_return
);
    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && mem_ready && !redir_valid |=> fetch_addr == $past(fetch_addr) + WORD_W'(2));

    assert_call_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        call_valid && !redir_valid |=> fetch_req && fetch_addr == $past(call_target));

    assert_call_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
        call_valid |-> call_target[0] == 1'b0);

    assert_operand_in_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_has_operand |-> fetch_req && mem_ready && op_operand == mem_rdata);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !mem_ready && !redir_valid |=> fetch_req && $stable(fetch_addr));

    assert_stall_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !mem_ready |-> !op_valid);

    assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> fetch_req && fetch_addr == $past(redir_target));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && call_valid));

    assert_operand_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_has_operand |-> op_valid);

endmodule

bind pword_decoder pwd_checker #(.WORD_W(WORD_W)) chk_i (.*);

// File: tb/pword_decoder_tb.sv
module pword_decoder_tb_top;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  mem_rdata = '0;
    logic          mem_ready = 1'b0;
    logic          redir_valid = 1'b0;
    logic [W-1:0]  redir_target = '0;
    logic          fetch_req;
    logic [W-1:0]  fetch_addr;
    logic          op_valid;
    logic [7:0]    op_code;
    logic          op_has_operand;
    logic [W-1:0]  op_operand;
    logic          call_valid;
    logic [W-1:0]  call_target;
    logic [W-1:0]  call_return;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pword_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .redir_valid(redir_valid), .redir_target(redir_target),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .op_valid(op_valid),
        .op_code(op_code), .op_has_operand(op_has_operand), .op_operand(op_operand),
        .call_valid(call_valid), .call_target(call_target), .call_return(call_return)
    );

    // Program, indexed by word (byte address / 2).
    // 0x78-0x7F take an operand; 0x79 is a taken jump; 0x06 is a return.
    function automatic logic [W-1:0] prog(input int idx);
        case (idx)
            0:  return 16'h0102;  // two plain opcodes
            1:  return 16'h7803;  // operand opcode in upper slot
            2:  return 16'h1234;
            3:  return 16'h047A;  // operand opcode in lower slot
            4:  return 16'hBEEF;
            5:  return 16'h800A;  // call to byte 20
            6:  return 16'h7907;  // jump, lower slot must be dropped
            7:  return 16'h001E;  // jump target byte 30
            10: return 16'h1106;  // routine body then return
            15: return 16'h2122;
            16: return 16'h8014;  // call to byte 40
            20: return 16'h3179;  // jump from lower slot
            21: return 16'h0000;  // back to byte 0
            default: return 16'h0909;
        endcase
    endfunction

    function automatic bit ready_pat(input int cyc);
        if (cyc < 300)      return 1'b1;
        else if (cyc < 600) return (cyc % 3) != 0;
        else                return (cyc % 7) >= 4;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model state
    int          m_pc;
    logic [7:0]  m_slots[$];
    int          m_wait;
    int          m_call;
    bit          m_after;
    int          rstack[$];

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "fetch_req", 32'(fetch_req), 32'd1);
        chk("R1", "fetch_addr", 32'(fetch_addr), 32'd0);
        chk("R1", "op_valid", 32'(op_valid), 32'd0);
        chk("R1", "call_valid", 32'(call_valid), 32'd0);
        rst_n = 1'b1;
        m_pc = 0; m_wait = -1; m_call = -1; m_after = 1'b0;
        begin
            bit prev_redir = 1'b0;
            for (int cyc = 0; cyc < 900; cyc++) begin
                bit          e_freq, e_op, e_has, e_call, rdy, do_redir;
                int          e_faddr, e_ctgt, e_cret, red_tgt;
                logic [7:0]  e_opc;
                logic [W-1:0] e_opnd, w;
                string       op_tag, f_tag;
                @(negedge clk);
                rdy = ready_pat(cyc);
                mem_ready = rdy;
                mem_rdata = prog(int'(fetch_addr[W-1:1]) % 64);
                e_freq = 0; e_op = 0; e_has = 0; e_call = 0;
                e_faddr = 0; e_ctgt = 0; e_cret = 0; e_opc = '0; e_opnd = '0;
                op_tag = "R3";
                if (m_wait >= 0) begin
                    e_freq = 1; e_faddr = m_pc;
                    if (rdy) begin
                        e_op = 1; e_has = 1; e_opc = 8'(m_wait);
                        e_opnd = prog(m_pc / 2); op_tag = "R5";
                        m_after = m_slots.size() > 0;
                        m_pc += 2; m_wait = -1;
                    end
                end else if (m_call >= 0) begin
                    e_call = 1; e_ctgt = m_call; e_cret = m_pc;
                    rstack.push_back(m_pc);
                    m_pc = m_call; m_call = -1;
                end else if (m_slots.size() > 0) begin
                    logic [7:0] b;
                    b = m_slots.pop_front();
                    if (m_after) op_tag = "R6";
                    m_after = 1'b0;
                    if (b[7:3] == 5'b01111) m_wait = int'(b);
                    else begin e_op = 1; e_opc = b; end
                end else begin
                    e_freq = 1; e_faddr = m_pc;
                    if (rdy) begin
                        w = prog(m_pc / 2);
                        m_pc += 2;
                        if (w[15]) m_call = int'({w[14:0], 1'b0});
                        else begin
                            m_slots.push_back(w[15:8]);
                            m_slots.push_back(w[7:0]);
                        end
                    end
                end
                // Execution side: jump and return redirect
                do_redir = 1'b0; red_tgt = 0;
                if (e_op && e_opc == 8'h79) begin
                    do_redir = 1'b1; red_tgt = int'(e_opnd);
                end else if (e_op && e_opc == 8'h06 && rstack.size() > 0) begin
                    do_redir = 1'b1; red_tgt = rstack.pop_back();
                end
                if (do_redir) begin
                    m_pc = red_tgt; m_slots.delete(); m_wait = -1; m_call = -1; m_after = 1'b0;
                end
                redir_valid  = do_redir;
                redir_target = W'(red_tgt);
                #1;
                f_tag = prev_redir ? "R8" : (rdy ? "R2" : "R7");
                chk(f_tag, "fetch_req", 32'(fetch_req), 32'(e_freq));
                if (e_freq) chk(f_tag, "fetch_addr", 32'(fetch_addr), 32'(e_faddr));
                chk(rdy ? op_tag : "R7", "op_valid", 32'(op_valid), 32'(e_op));
                if (e_op) begin
                    chk(op_tag, "op_code", 32'(op_code), 32'(e_opc));
                    chk(op_tag, "op_has_operand", 32'(op_has_operand), 32'(e_has));
                    if (e_has) chk("R5", "op_operand", 32'(op_operand), 32'(e_opnd));
                end
                chk("R4", "call_valid", 32'(call_valid), 32'(e_call));
                if (e_call) begin
                    chk("R4", "call_target", 32'(call_target), 32'(e_ctgt));
                    chk("R4", "call_return", 32'(call_return), 32'(e_cret));
                end
                chk("R9", "op_and_call", 32'(op_valid && call_valid), 32'd0);
                prev_redir = do_redir;
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual running expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule